// File: doc/BRIEF.md
# Framed Serial Flash Master

This block drives an SPI flash as a bus master. The serial clock keeps running while the block is enabled. The chip select is an active-low frame strobe that brackets each word. The serial clock comes from the system clock through a programmable half-period divider. Its fastest setting is a ratio of two. The transmit and receive shifters run on that single serial clock, so each bit out on MOSI is matched by a bit captured from MISO on the same clock.

A word enters through a valid/ready port into a one-word holding register. It starts on the next falling serial edge. The select drops in the same cycle that the first bit appears on MOSI. If another word is waiting when the last bit of the current word has been sampled, that word follows at once and the select stays low across the boundary. Otherwise the select returns high. Later clock edges then go to a deselected device. Each received word is returned with a single-cycle valid strobe.

Top module: `framed_spi_master`

## Requirements
- R1: While reset is asserted, or while `enable` is low, the outputs read `sck`=0, `cs_n`=1, `mosi`=0 and `rx_valid`=0.
- R2: While enabled, `sck` is a free-running square wave with a period of 2*max(`div_half`,1) system cycles, whether or not data is moving. A setting of 0 therefore acts like 1, which gives the fastest ratio of 2.
- R3: `cs_n` goes low only in the cycle in which `sck` falls. In that same cycle `mosi` carries the most significant bit of the word just started.
- R4: Words leave most significant bit first. `mosi` changes only together with a falling `sck` edge, or when the block parks or is disabled.
- R5: `cs_n` stays low for exactly WORD_W serial periods per word. If a word is held in the buffer when the last bit is sampled, the next word starts at the following falling edge with `cs_n` kept low. Otherwise `cs_n` rises at that falling edge.
- R6: No word is ever shifted without framing. With nothing to send, `cs_n` stays high and `mosi` stays 0 while `sck` keeps toggling.
- R7: `miso` is sampled on rising `sck` edges, most significant bit first. One cycle after the rising edge that takes the last bit, `rx_valid` is high for exactly one cycle, with the whole word on `rx_data`.
- R8: `tx_ready` is high exactly when the holding register is empty. A word is accepted on a clock edge where `tx_valid` and `tx_ready` are both high, and `tx_ready` falls on the next cycle.
- R9: Dropping `enable` abandons any word in flight. On the next cycle the outputs reach the idle state of R1. A word in the holding register is kept, and it is sent after `enable` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the serial clock and framing when high |
| div_half | input | DIV_W | System cycles per half serial period (0 acts as 1) |
| tx_data | input | WORD_W | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register empty |
| rx_data | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low frame select to the device |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench goes after the word boundary. A design that sampled the holding register one edge too late would release the select for a period between buffered words. One that ignored the buffer check would send a word with the select high. Divider settings of 0, 1 and 3 expose an off-by-one count, which would show up as a wrong serial period or a missed divide-by-two. Turning `enable` off in mid-word shows whether a design leaves the select low or drops the buffered word. A random MISO stream is compared bit by bit against an independent model, which catches capture on the wrong edge or bits assembled in the wrong order.

// File: rtl/frmser_pkg.sv
package frmser_pkg;

  // Strobes issued by the sequencer to the shift datapath, one cycle each.
  typedef struct packed {
    logic acceptWord; // holding register takes tx_data
    logic startWord;  // shifter loads from holding register, first bit out
    logic shiftBit;   // advance transmit shifter on a falling edge
    logic sampleBit;  // capture miso on a rising edge
    logic wordDone;   // this sample completes the received word
    logic park;       // clear the transmit line
  } ctrlStrobes_t;

endpackage

// File: rtl/frmser_ctrl.sv
module frmser_ctrl
  import frmser_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divHalf,
  input  logic             txValid,
  output logic             txReady,
  output logic             sck,
  output logic             csN,
  output ctrlStrobes_t     strobes
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  logic [DIV_W-1:0] halfCnt;
  logic [DIV_W-1:0] halfLim;
  logic [CNT_W-1:0] bitCnt;
  logic             active;
  logic             bufValid;
  logic             tick, riseEv, fallEv;
  logic             wordFull, bitsLeft, boundary;

  assign halfLim  = (divHalf == '0) ? DIV_W'(1) : divHalf;
  assign tick     = enable && (halfCnt >= halfLim - DIV_W'(1));
  assign riseEv   = tick && !sck;
  assign fallEv   = tick && sck;
  assign wordFull = (bitCnt == FULL_CNT);
  assign bitsLeft = active && !wordFull;
  assign boundary = fallEv && (!active || wordFull);

  always_comb begin
    strobes            = '0;
    strobes.acceptWord = txValid && !bufValid;
    strobes.startWord  = boundary && bufValid;
    strobes.shiftBit   = fallEv && bitsLeft;
    strobes.sampleBit  = riseEv && bitsLeft;
    strobes.wordDone   = riseEv && bitsLeft && (bitCnt == LAST_IDX);
    strobes.park       = !enable || (boundary && !bufValid);
  end

  assign txReady = !bufValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfCnt <= '0;
      sck     <= 1'b0;
      csN     <= 1'b1;
      active  <= 1'b0;
      bitCnt  <= '0;
    end else if (!enable) begin
      halfCnt <= '0;
      sck     <= 1'b0;
      csN     <= 1'b1;
      active  <= 1'b0;
      bitCnt  <= '0;
    end else begin
      halfCnt <= tick ? '0 : halfCnt + DIV_W'(1);
      if (tick) sck <= ~sck;
      if (strobes.startWord) begin
        active <= 1'b1;
        csN    <= 1'b0;
        bitCnt <= '0;
      end else if (boundary) begin
        active <= 1'b0;
        csN    <= 1'b1;
      end else if (strobes.sampleBit) begin
        bitCnt <= bitCnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  bufValid <= 1'b0;
    else if (strobes.acceptWord) bufValid <= 1'b1;
    else if (strobes.startWord)  bufValid <= 1'b0;
  end

  // R1: with enable low the serial pins sit idle on the following cycle
  assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sck && csN));

  // R3: the select can only open together with a falling serial edge
  assert_cs_opens_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> $fell(sck));

  // R5: the select closes only at a falling edge or after disabling
  assert_cs_closes_on_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> ($fell(sck) || !$past(enable)));

endmodule

// File: rtl/frmser_dp.sv
module frmser_dp
  import frmser_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [WORD_W-1:0] txData,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rxData,
  output logic              rxValid
);

  logic [WORD_W-1:0] bufData;
  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;
  logic [WORD_W-1:0] rxNext;

  assign rxNext = {rxShift[WORD_W-2:0], miso};
  assign mosi   = txShift[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rstN)                   bufData <= '0;
    else if (strobes.acceptWord) bufData <= txData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  txShift <= '0;
    else if (strobes.park)      txShift <= '0;
    else if (strobes.startWord) txShift <= bufData;
    else if (strobes.shiftBit)  txShift <= {txShift[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= strobes.wordDone;
      if (strobes.sampleBit) rxShift <= rxNext;
      if (strobes.wordDone)  rxData  <= rxNext;
    end
  end

  // R4: the transmit line moves only on a sequencer strobe
  assert_mosi_moves_on_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mosi) |-> $past(strobes.startWord || strobes.shiftBit || strobes.park));

  // R7: a received word is flagged for a single cycle
  assert_rx_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

endmodule

// File: rtl/framed_spi_master.sv
module framed_spi_master
  import frmser_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DIV_W-1:0]  div_half,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);

  ctrlStrobes_t strobes;

  frmser_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rst_n),
    .enable  (enable),
    .divHalf (div_half),
    .txValid (tx_valid),
    .txReady (tx_ready),
    .sck     (sck),
    .csN     (cs_n),
    .strobes (strobes)
  );

  frmser_dp #(.WORD_W(WORD_W)) u_dp (
    .clk     (clk),
    .rstN    (rst_n),
    .strobes (strobes),
    .txData  (tx_data),
    .miso    (miso),
    .mosi    (mosi),
    .rxData  (rx_data),
    .rxValid (rx_valid)
  );

endmodule

// File: tb/framed_spi_master_tb.sv
module framed_spi_master_tb;
  localparam int W  = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [DW-1:0] div_half = DW'(1);
  logic [W-1:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready;
  logic [W-1:0] rx_data;
  logic rx_valid;
  logic sck, cs_n, mosi;
  logic miso = 1'b0;

  always #4 clk = ~clk;

  framed_spi_master #(.WORD_W(W), .DIV_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_half(div_half),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Device stand-in: fresh random bit on MISO every system cycle.
  always @(negedge clk) miso <= 1'($urandom_range(0, 1));

  // Behavioural reference model.
  int mSck = 0, mCs = 1, mMosi = 0, mRxV = 0, mRxD = 0;
  int mHalf = 0, mBits = 0, mActive = 0, mWord = 0, mAcc = 0;
  int q[$];

  always @(posedge clk) begin
    int lim;
    bit wasEmpty;
    wasEmpty = (q.size() == 0);
    if (!rst_n) begin
      mSck = 0; mCs = 1; mMosi = 0; mRxV = 0; mHalf = 0; mBits = 0; mActive = 0;
      q.delete();
    end else begin
      if (!enable) begin
        mSck = 0; mCs = 1; mMosi = 0; mRxV = 0; mHalf = 0; mBits = 0; mActive = 0;
      end else begin
        mRxV = 0;
        lim = (div_half == 0) ? 1 : int'(div_half);
        if (mHalf >= lim - 1) begin
          mHalf = 0;
          if (mSck == 0) begin
            mSck = 1;
            if (mActive && mBits < W) begin
              mAcc = ((mAcc << 1) | int'(miso)) & ((1 << W) - 1);
              mBits++;
              if (mBits == W) begin mRxD = mAcc; mRxV = 1; end
            end
          end else begin
            mSck = 0;
            if (mActive && mBits < W) begin
              mWord = (mWord << 1) & ((1 << W) - 1);
              mMosi = (mWord >> (W - 1)) & 1;
            end else if (q.size() != 0) begin
              mWord = q.pop_front();
              mMosi = (mWord >> (W - 1)) & 1;
              mCs = 0; mActive = 1; mBits = 0;
            end else begin
              mCs = 1; mMosi = 0; mActive = 0;
            end
          end
        end else begin
          mHalf++;
        end
      end
      if (tx_valid && wasEmpty) q.push_back(int'(tx_data));
    end
  end

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(sck == 1'(mSck), "R2", "sck", sck, mSck);
      chk(cs_n == 1'(mCs), "R3", "cs_n", cs_n, mCs);
      chk(mosi == 1'(mMosi), "R4", "mosi", mosi, mMosi);
      chk(rx_valid == 1'(mRxV), "R7", "rx_valid", rx_valid, mRxV);
      if (mRxV) chk(rx_data == W'(mRxD), "R7", "rx_data", rx_data, mRxD);
      chk(tx_ready == (q.size() == 0), "R8", "tx_ready", tx_ready, q.size() == 0);
    end
  end

  task automatic push_word(input logic [W-1:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic get_period(output int p);
    p = 0;
    do @(negedge clk); while (sck !== 1'b0);
    do @(negedge clk); while (sck !== 1'b1);
    do begin @(negedge clk); p++; end while (sck !== 1'b0);
    do begin @(negedge clk); p++; end while (sck !== 1'b1);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(tx_ready && cs_n));
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int p, lowCnt, highCnt, rxCnt;
    repeat (5) @(negedge clk);
    // R1 / R8: reset state
    chk(sck == 0 && cs_n == 1 && mosi == 0 && rx_valid == 0, "R1", "reset idle", {sck, cs_n, mosi}, 3'b010);
    chk(tx_ready == 1, "R8", "tx_ready in reset", tx_ready, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sck == 0 && cs_n == 1, "R1", "disabled idle", {sck, cs_n}, 2'b01);

    // R2 / R6: fastest ratio, free-running clock with select held high
    div_half = DW'(1);
    enable = 1'b1;
    get_period(p);
    chk(p == 2, "R2", "period div1", p, 2);
    lowCnt = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (!cs_n || mosi) lowCnt++; end
    chk(lowCnt == 0, "R6", "idle edges deselected", lowCnt, 0);

    // R5: single word holds select for W periods
    push_word(8'hA5);
    do @(negedge clk); while (cs_n);
    lowCnt = 0;
    while (!cs_n) begin lowCnt++; @(negedge clk); end
    chk(lowCnt == 2 * W, "R5", "select width", lowCnt, 2 * W);
    wait_idle();

    // R5: back-to-back words keep select low
    highCnt = 0; rxCnt = 0;
    fork
      begin push_word(8'h3C); push_word(8'hF0); push_word(8'h81); end
      begin
        do @(negedge clk); while (cs_n);
        while (rxCnt < 3) begin
          @(negedge clk);
          if (rx_valid) rxCnt++;
          if (cs_n && rxCnt < 3) highCnt++;
        end
      end
    join
    chk(highCnt == 0, "R5", "gap between buffered words", highCnt, 0);
    chk(rxCnt == 3, "R7", "words received", rxCnt, 3);
    wait_idle();

    // R2: zero divider acts as one
    enable = 1'b0;
    div_half = '0;
    @(negedge clk);
    enable = 1'b1;
    get_period(p);
    chk(p == 2, "R2", "period div0", p, 2);
    push_word(8'h5A);
    wait_idle();

    // R2 / R5: slower ratio with a gap between words
    enable = 1'b0;
    div_half = DW'(3);
    @(negedge clk);
    enable = 1'b1;
    get_period(p);
    chk(p == 6, "R2", "period div3", p, 6);
    push_word(8'hC3);
    wait_idle();
    push_word(8'h7E);
    wait_idle();

    // R9: disable mid-word, keep the buffered word
    push_word(8'h99);
    push_word(8'h66);
    do @(negedge clk); while (cs_n);
    repeat (10) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(sck == 0 && cs_n == 1 && mosi == 0, "R9", "idle after disable", {sck, cs_n, mosi}, 3'b010);
    repeat (8) @(negedge clk);
    chk(tx_ready == 0, "R9", "buffered word kept", tx_ready, 0);
    enable = 1'b1;
    wait_idle();
    chk(tx_ready == 1, "R9", "buffered word sent", tx_ready, 1);

    finish_run();
  end
endmodule